// File: doc/BRIEF.md
# Multiprotocol Serial Port with Multidrop Addressing

This block is one asynchronous serial channel. It has a transmitter, a receiver, and a first-in first-out queue in each direction. A character carries 5 to 9 data bits, sent least significant bit first. A parity bit may follow the data: even, odd, always zero, always one, or none. One stop bit closes the frame. Both directions share one bit clock, built from a 16-bit divisor with sixteen ticks per bit. The receiver samples each bit at its middle.

Settings are plain configuration inputs. The host loads characters through a write strobe and reads them back from the head of the receive queue. Four sticky status flags report problems, and `status_clr` clears them.

With 9-bit characters the ninth bit marks an address character. When the node filter is on, the receiver keeps only the data that follows an address equal to the node's own. Flow control works in two ways:
- **Hardware:** a clear-to-send input and a request-to-send output.
- **Software:** received pause and resume codes gate the transmitter.

Top module: `uart_mp_top`

## Requirements
- R1: After reset the state is as follows:
  - `txd` is 1.
  - `rx_empty` is 1 and `tx_full` is 0.
  - `rts_n` is 0 while `hw_flow_en` is 0.
  - All four status flags are 0.
- R2: A transmitted frame has these parts, in order:
  - one start bit of 0;
  - `char_bits` data bits, least significant first;
  - an optional parity bit;
  - one stop bit of 1.

  Each bit lasts 16×`baud_div` clocks, and a `baud_div` of 0 acts as 1. `txd` rests at 1 between frames.
- R3: `parity_mode` selects the parity bit:
  - 0: no parity bit;
  - 1: even (data plus parity has an even count of ones);
  - 2: odd;
  - 3: always 0;
  - 4: always 1;
  - 5 to 7: no parity bit.

  A received character whose parity bit mismatches is discarded and sets `flag_parity`.
- R4: `char_bits` selects 5 to 9 data bits. A value below 5 acts as 5 and a value above 9 acts as 9. `rx_data` holds the received character right-aligned, with the unused upper bits at 0. Transmit ignores the `tx_data` bits above the length.
- R5: Each queue holds DEPTH characters. `tx_full` is 1 once DEPTH characters wait to be sent. A write while the queue is full is ignored, and that character never appears on the line.
- R6: With `md_en`=1 and 9-bit characters, a character with bit 8 = 1 is an address and is never stored.
  - An address whose bits 7..0 equal `node_addr` enables storing of the data characters that follow.
  - Any other address disables it.
  - Filtering starts disabled after reset.
- R7: With `sw_flow_en`=1, a received 0x13 (bit 8 clear) stops new transmissions after the current frame. A received 0x11 lets them start again. Neither code is stored. With `sw_flow_en`=0 both codes are stored as ordinary data.
- R8: With `hw_flow_en`=1:
  - no new frame starts while `cts_n` is 1;
  - `rts_n` is 1 while the receive queue holds at least DEPTH−RTS_HEADROOM characters, and 0 otherwise.
- R9: A character that would be stored while the receive queue is full is dropped and sets the sticky `flag_overrun`. The queued characters are unchanged.
- R10: A stop bit sampled as 0 discards the character and sets a flag:
  - `flag_break` if every data and parity bit was also 0;
  - `flag_framing` otherwise.

  The receiver then waits for the line to go high before looking for a new frame.
- R11: A `status_clr` pulse clears all four flags. An event in the same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_div | input | DIV_W | Clocks per oversampling tick |
| char_bits | input | 4 | Data bits per character (5..9) |
| parity_mode | input | 3 | Parity selection, see R3 |
| hw_flow_en | input | 1 | Enable clear-to-send / request-to-send flow control |
| sw_flow_en | input | 1 | Enable in-band pause/resume codes |
| md_en | input | 1 | Enable multidrop address filtering |
| node_addr | input | 8 | This node's address |
| status_clr | input | 1 | Clear sticky flags |
| tx_wr | input | 1 | Write strobe into transmit queue |
| tx_data | input | 9 | Character to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_rd | input | 1 | Pop the head of the receive queue |
| rx_data | output | 9 | Head of receive queue |
| rx_empty | output | 1 | Receive queue empty |
| flag_overrun | output | 1 | Sticky receive overrun |
| flag_framing | output | 1 | Sticky framing error |
| flag_parity | output | 1 | Sticky parity error |
| flag_break | output | 1 | Sticky break seen |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| cts_n | input | 1 | Clear to send, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
The hardest conditions to reach involve a full queue, because filling one needs many whole frames.

- **Dropped write (R5):** the bench holds `cts_n` high so nothing drains, fills the transmit queue and offers one extra character. After releasing `cts_n` it checks that the extra character never arrives through the loopback.
- **Overrun (R9):** the bench fills the receive queue through the loopback without popping it, then sends one more frame.
- **Break (R10):** the bench holds `rxd` low for longer than a frame.
- **Software flow control (R7):** the bench drives pause codes into `rxd` while a character waits to be sent.

// File: rtl/uart_mp_pkg.sv
package uart_mp_pkg;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_EVEN  = 3'd1,
        PAR_ODD   = 3'd2,
        PAR_SPACE = 3'd3,
        PAR_MARK  = 3'd4
    } par_mode_e;

    localparam logic [7:0] PAUSE_CODE  = 8'h13;
    localparam logic [7:0] RESUME_CODE = 8'h11;

    // parity bit for the low nb bits of d
    function automatic logic par_calc(par_mode_e m, logic [8:0] d, logic [3:0] nb);
        logic [8:0] mask;
        mask = 9'h1FF >> (4'd9 - nb);
        case (m)
            PAR_EVEN: return ^(d & mask);
            PAR_ODD:  return ~^(d & mask);
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_mp_fifo.sv
module uart_mp_fifo #(
    parameter int unsigned W     = 9,
    parameter int unsigned DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [W-1:0]             wdata,
    input  logic                     pop,
    output logic [W-1:0]             rdata,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_s;

    fifo_s st_d, st_q;
    logic  do_push, do_pop;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != (AW+1)'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) st_d.wp = st_q.wp + AW'(1);
        if (do_pop)  st_d.rp = st_q.rp + AW'(1);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + (AW+1)'(1);
            2'b01:   st_d.cnt = st_q.cnt - (AW+1)'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= wdata;
    end

    assign rdata = mem[st_q.rp];
    assign level = st_q.cnt;
endmodule

// File: rtl/uart_mp_tx.sv
module uart_mp_tx
    import uart_mp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       go,
    input  logic [8:0] din,
    input  logic [3:0] nbits,
    input  par_mode_e  pmode,
    output logic       take,
    output logic       txd,
    output logic       busy
);
    typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;

    typedef struct packed {
        tst_e       st;
        logic [3:0] sub;
        logic [3:0] bitn;
        logic [8:0] sh;
        logic       pb;
    } tx_s;

    tx_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        if (st_q.st == T_IDLE) begin
            // frames start on a tick so every bit is exactly 16 ticks
            if (go && tick) begin
                take      = 1'b1;
                st_d.st   = T_START;
                st_d.sub  = '0;
                st_d.sh   = din;
                st_d.pb   = par_calc(pmode, din, nbits);
            end
        end else if (tick) begin
            st_d.sub = st_q.sub + 4'd1;
            if (st_q.sub == 4'd15) begin
                case (st_q.st)
                    T_START: begin
                        st_d.st   = T_DATA;
                        st_d.bitn = '0;
                    end
                    T_DATA: begin
                        st_d.sh   = st_q.sh >> 1;
                        st_d.bitn = st_q.bitn + 4'd1;
                        if (st_q.bitn == nbits - 4'd1)
                            st_d.st = (pmode == PAR_NONE) ? T_STOP : T_PAR;
                    end
                    T_PAR:   st_d.st = T_STOP;
                    default: st_d.st = T_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: T_IDLE, default: '0};
        else        st_q <= st_d;
    end

    always_comb begin
        case (st_q.st)
            T_START: txd = 1'b0;
            T_DATA:  txd = st_q.sh[0];
            T_PAR:   txd = st_q.pb;
            default: txd = 1'b1;
        endcase
    end

    assign busy = (st_q.st != T_IDLE);
endmodule

// File: rtl/uart_mp_rx.sv
module uart_mp_rx
    import uart_mp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [3:0] nbits,
    input  par_mode_e  pmode,
    output logic       valid,
    output logic [8:0] data,
    output logic       ferr,
    output logic       perr,
    output logic       brk
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_HOLD} rst_e;

    typedef struct packed {
        logic       s1;
        logic       s2;
        rst_e       st;
        logic [3:0] sub;
        logic [3:0] bitn;
        logic [8:0] sh;
        logic       pb;
        logic       zero;
        logic       valid;
        logic [8:0] data;
        logic       ferr;
        logic       perr;
        logic       brk;
    } rx_s;

    rx_s        st_d, st_q;
    logic       line;
    logic [8:0] aligned;

    always_comb begin
        st_d       = st_q;
        st_d.s1    = rxd;
        st_d.s2    = st_q.s1;
        st_d.valid = 1'b0;
        st_d.ferr  = 1'b0;
        st_d.perr  = 1'b0;
        st_d.brk   = 1'b0;
        line       = st_q.s2;
        aligned    = st_q.sh >> (4'd9 - nbits);
        case (st_q.st)
            R_IDLE: if (tick && !line) begin
                st_d.st  = R_START;
                st_d.sub = '0;
            end
            R_HOLD: if (line) st_d.st = R_IDLE;
            default: if (tick) begin
                st_d.sub = st_q.sub + 4'd1;
                if (st_q.st == R_START) begin
                    if (st_q.sub == 4'd7) begin
                        st_d.sub = '0;
                        if (line) st_d.st = R_IDLE;
                        else begin
                            st_d.st   = R_DATA;
                            st_d.bitn = '0;
                            st_d.sh   = '0;
                            st_d.zero = 1'b1;
                        end
                    end
                end else if (st_q.sub == 4'd15) begin
                    case (st_q.st)
                        R_DATA: begin
                            st_d.sh   = {line, st_q.sh[8:1]};
                            st_d.zero = st_q.zero & ~line;
                            st_d.bitn = st_q.bitn + 4'd1;
                            if (st_q.bitn == nbits - 4'd1)
                                st_d.st = (pmode == PAR_NONE) ? R_STOP : R_PAR;
                        end
                        R_PAR: begin
                            st_d.pb   = line;
                            st_d.zero = st_q.zero & ~line;
                            st_d.st   = R_STOP;
                        end
                        default: begin
                            if (!line) begin
                                st_d.st = R_HOLD;
                                if (st_q.zero) st_d.brk  = 1'b1;
                                else           st_d.ferr = 1'b1;
                            end else begin
                                st_d.st = R_IDLE;
                                if (pmode != PAR_NONE &&
                                    st_q.pb != par_calc(pmode, aligned, nbits))
                                    st_d.perr = 1'b1;
                                else begin
                                    st_d.valid = 1'b1;
                                    st_d.data  = aligned;
                                end
                            end
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, st: R_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;
    assign ferr  = st_q.ferr;
    assign perr  = st_q.perr;
    assign brk   = st_q.brk;
endmodule

// File: rtl/uart_mp_top.sv
module uart_mp_top
    import uart_mp_pkg::*;
#(
    parameter int unsigned DEPTH        = 256,
    parameter int unsigned RTS_HEADROOM = 16,
    parameter int unsigned DIV_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic [3:0]       char_bits,
    input  logic [2:0]       parity_mode,
    input  logic             hw_flow_en,
    input  logic             sw_flow_en,
    input  logic             md_en,
    input  logic [7:0]       node_addr,
    input  logic             status_clr,
    input  logic             tx_wr,
    input  logic [8:0]       tx_data,
    output logic             tx_full,
    input  logic             rx_rd,
    output logic [8:0]       rx_data,
    output logic             rx_empty,
    output logic             flag_overrun,
    output logic             flag_framing,
    output logic             flag_parity,
    output logic             flag_break,
    input  logic             rxd,
    output logic             txd,
    input  logic             cts_n,
    output logic             rts_n
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
    localparam logic [CW-1:0] RTS_LVL  = CW'(DEPTH - RTS_HEADROOM);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             xoff;
        logic             match;
        logic             ovr;
        logic             ferr;
        logic             perr;
        logic             brk;
    } top_s;

    top_s st_d, st_q;

    logic [DIV_W-1:0] div_m1;
    logic             tick;
    logic [3:0]       nbits;
    par_mode_e        pmode;
    logic [CW-1:0]    tx_level, rx_level;
    logic [8:0]       tx_head, rx_char;
    logic             tx_empty, rx_full, tx_take, tx_go, tx_busy;
    logic             rx_valid, rx_ferr, rx_perr, rx_brk, rx_push, is_addr;
    logic             xoff_w;

    assign div_m1   = (baud_div == '0) ? '0 : baud_div - DIV_W'(1);
    assign tick     = (st_q.cnt >= div_m1);
    assign nbits    = (char_bits < 4'd5) ? 4'd5 : (char_bits > 4'd9) ? 4'd9 : char_bits;
    assign pmode    = (parity_mode > 3'd4) ? PAR_NONE : par_mode_e'(parity_mode);
    assign tx_full  = (tx_level == FULL_LVL);
    assign tx_empty = (tx_level == '0);
    assign rx_full  = (rx_level == FULL_LVL);
    assign rx_empty = (rx_level == '0);
    assign is_addr  = (nbits == 4'd9) && rx_char[8];
    assign tx_go    = !tx_empty && !(hw_flow_en && cts_n) && !(sw_flow_en && st_q.xoff);
    assign rts_n    = hw_flow_en && (rx_level >= RTS_LVL);
    assign xoff_w   = st_q.xoff;

    always_comb begin
        st_d     = st_q;
        rx_push  = 1'b0;
        st_d.cnt = tick ? '0 : st_q.cnt + DIV_W'(1);
        if (!sw_flow_en) st_d.xoff = 1'b0;
        if (status_clr) begin
            st_d.ovr  = 1'b0;
            st_d.ferr = 1'b0;
            st_d.perr = 1'b0;
            st_d.brk  = 1'b0;
        end
        if (rx_ferr) st_d.ferr = 1'b1;
        if (rx_perr) st_d.perr = 1'b1;
        if (rx_brk)  st_d.brk  = 1'b1;
        if (rx_valid) begin
            if (sw_flow_en && !is_addr && rx_char[7:0] == PAUSE_CODE)
                st_d.xoff = 1'b1;
            else if (sw_flow_en && !is_addr && rx_char[7:0] == RESUME_CODE)
                st_d.xoff = 1'b0;
            else if (md_en && is_addr)
                st_d.match = (rx_char[7:0] == node_addr);
            else if (!md_en || nbits != 4'd9 || st_q.match) begin
                if (rx_full) st_d.ovr = 1'b1;
                else         rx_push  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_overrun = st_q.ovr;
    assign flag_framing = st_q.ferr;
    assign flag_parity  = st_q.perr;
    assign flag_break   = st_q.brk;

    uart_mp_fifo #(.W(9), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_wr), .wdata(tx_data),
        .pop(tx_take), .rdata(tx_head), .level(tx_level)
    );

    uart_mp_fifo #(.W(9), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_char),
        .pop(rx_rd), .rdata(rx_data), .level(rx_level)
    );

    uart_mp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .go(tx_go), .din(tx_head),
        .nbits(nbits), .pmode(pmode), .take(tx_take), .txd(txd), .busy(tx_busy)
    );

    uart_mp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .nbits(nbits),
        .pmode(pmode), .valid(rx_valid), .data(rx_char), .ferr(rx_ferr),
        .perr(rx_perr), .brk(rx_brk)
    );
endmodule

// File: rtl/uart_mp_chk.sv
module uart_mp_chk #(
    parameter int unsigned DEPTH = 256
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   txd,
    input logic                   tx_busy,
    input logic                   hw_flow_en,
    input logic                   cts_n,
    input logic                   sw_flow_en,
    input logic                   xoff,
    input logic                   rx_full,
    input logic                   overrun,
    input logic [$clog2(DEPTH):0] rx_level,
    input logic                   rx_push,
    input logic                   md_en,
    input logic [3:0]             nbits,
    input logic [8:0]             rx_char
);
    // R2
    line_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R8
    cts_gates_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !$past(hw_flow_en && cts_n));

    // R7
    pause_gates_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !$past(sw_flow_en && xoff));

    // R9
    overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_full));

    // R5
    rx_level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= ($clog2(DEPTH)+1)'(DEPTH));

    // R6
    no_addr_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && md_en && nbits == 4'd9) |-> !rx_char[8]);
endmodule

bind uart_mp_top uart_mp_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
    .hw_flow_en(hw_flow_en), .cts_n(cts_n), .sw_flow_en(sw_flow_en),
    .xoff(xoff_w), .rx_full(rx_full), .overrun(flag_overrun),
    .rx_level(rx_level), .rx_push(rx_push), .md_en(md_en),
    .nbits(nbits), .rx_char(rx_char)
);

// File: tb/sim_uart_mp_top.sv
module sim_uart_mp_top;
    localparam int DEPTH = 16;
    localparam int HEAD  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] baud_div = 16'd1;
    logic [3:0]  char_bits = 4'd8;
    logic [2:0]  parity_mode = 3'd0;
    logic hw_flow_en = 1'b0, sw_flow_en = 1'b0, md_en = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic status_clr = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [8:0] tx_data = '0;
    logic tx_full, rx_empty, flag_overrun, flag_framing, flag_parity, flag_break;
    logic [8:0] rx_data;
    logic txd, rts_n, rxd;
    logic cts_n = 1'b0, lb = 1'b1, drv_rxd = 1'b1;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    assign rxd = lb ? txd : drv_rxd;

    always #4 clk = ~clk;

    uart_mp_top #(.DEPTH(DEPTH), .RTS_HEADROOM(HEAD), .DIV_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .char_bits(char_bits),
        .parity_mode(parity_mode), .hw_flow_en(hw_flow_en), .sw_flow_en(sw_flow_en),
        .md_en(md_en), .node_addr(node_addr), .status_clr(status_clr),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_empty(rx_empty), .flag_overrun(flag_overrun),
        .flag_framing(flag_framing), .flag_parity(flag_parity),
        .flag_break(flag_break), .rxd(rxd), .txd(txd), .cts_n(cts_n), .rts_n(rts_n)
    );

    // {bits[15:12], parity[11:9], value[8:0]}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {4'd8, 3'd0, 9'h0A5}, {4'd8, 3'd1, 9'h03C}, {4'd8, 3'd2, 9'h03C},
        {4'd7, 3'd3, 9'h07F}, {4'd7, 3'd4, 9'h000}, {4'd5, 3'd1, 9'h1F5},
        {4'd6, 3'd2, 9'h12A}, {4'd9, 3'd0, 9'h1C3}, {4'd9, 3'd1, 9'h155},
        {4'd9, 3'd4, 9'h0FF}, {4'd5, 3'd3, 9'h013}, {4'd8, 3'd0, 9'h011}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_par(input int pm, input logic [8:0] v, input int nb);
        logic p = 1'b0;
        for (int i = 0; i < nb; i++) p ^= v[i];
        case (pm)
            1: return p;
            2: return ~p;
            4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic tx_push(input logic [8:0] v);
        @(negedge clk); tx_wr = 1'b1; tx_data = v;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic rx_pop(output logic [8:0] v);
        @(negedge clk); v = rx_data; rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic wait_rx(input int lim);
        for (int t = 0; t < lim; t++) begin
            @(negedge clk);
            if (!rx_empty) break;
        end
    endtask

    // drive one frame on rxd at divisor 1
    task automatic send_raw(input logic [8:0] v, input int nb, input bit hp,
                            input logic pb, input logic stop);
        @(negedge clk); drv_rxd = 1'b0;
        repeat (16) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            drv_rxd = v[i]; repeat (16) @(negedge clk);
        end
        if (hp) begin drv_rxd = pb; repeat (16) @(negedge clk); end
        drv_rxd = stop; repeat (16) @(negedge clk);
        drv_rxd = 1'b1; repeat (24) @(negedge clk);
    endtask

    task automatic capture_tx(input int nb, input bit hp, output logic [11:0] fr, output bit ok);
        int n;
        ok = 1'b0; fr = '0;
        for (int t = 0; t < 2000; t++) begin
            @(negedge clk);
            if (txd == 1'b0) begin ok = 1'b1; break; end
        end
        if (!ok) return;
        repeat (8) @(negedge clk);
        fr[0] = txd;
        n = nb + (hp ? 1 : 0) + 1;
        for (int i = 1; i <= n; i++) begin
            repeat (16) @(negedge clk);
            fr[i] = txd;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [8:0] got;
        logic [11:0] fr, efr;
        bit ok;
        int nb, pm, len;
        bit hp, low_seen;
        logic [8:0] v, m;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd", txd, 1);
        check(rx_empty == 1'b1 && tx_full == 1'b0, "R1 queues", {rx_empty, tx_full}, 2'b10);
        check(rts_n == 1'b0, "R1 rts_n", rts_n, 0);
        check({flag_overrun, flag_framing, flag_parity, flag_break} == 4'b0, "R1 flags",
              {flag_overrun, flag_framing, flag_parity, flag_break}, 0);

        // table walk over lengths and parity modes, loopback (R2 R3 R4)
        lb = 1'b1;
        for (int k = 0; k < NV; k++) begin
            nb = int'(VEC[k][15:12]); pm = int'(VEC[k][11:9]); v = VEC[k][8:0];
            hp = (pm != 0);
            @(negedge clk); char_bits = VEC[k][15:12]; parity_mode = VEC[k][11:9];
            m = 9'h1FF >> (9 - nb);
            efr = '0;
            for (int i = 0; i < nb; i++) efr[1+i] = v[i];
            if (hp) efr[1+nb] = exp_par(pm, v, nb);
            efr[1+nb+(hp ? 1 : 0)] = 1'b1;
            tx_push(v);
            capture_tx(nb, hp, fr, ok);
            check(ok && fr == efr, "R2 R3 frame bits", fr, efr);
            wait_rx(200);
            rx_pop(got);
            check(got == (v & m), "R4 R3 rx data", got, v & m);
        end

        // R2 bit time with divisor 3
        @(negedge clk); char_bits = 4'd8; parity_mode = 3'd0; baud_div = 16'd3;
        tx_push(9'h0FF);
        len = 0; low_seen = 0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (txd == 1'b0) begin len++; low_seen = 1; end
            else if (low_seen) break;
        end
        check(len == 48, "R2 start bit length", len, 48);
        wait_rx(800);
        rx_pop(got);
        check(got == 9'h0FF, "R2 rx at divisor 3", got, 9'h0FF);
        @(negedge clk); baud_div = 16'd1;
        repeat (40) @(negedge clk);

        // R3 parity error on received frame
        lb = 1'b0;
        @(negedge clk); parity_mode = 3'd1;
        send_raw(9'h003, 8, 1, 1'b1, 1'b1);
        check(flag_parity == 1'b1, "R3 parity flag", flag_parity, 1);
        check(rx_empty == 1'b1, "R3 bad parity discarded", rx_empty, 1);

        // R10 framing and break
        @(negedge clk); parity_mode = 3'd0;
        send_raw(9'h055, 8, 0, 1'b0, 1'b0);
        check(flag_framing == 1'b1 && flag_break == 1'b0, "R10 framing",
              {flag_framing, flag_break}, 2'b10);
        check(rx_empty == 1'b1, "R10 framing discarded", rx_empty, 1);
        @(negedge clk); drv_rxd = 1'b0;
        repeat (16 * 14) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (40) @(negedge clk);
        check(flag_break == 1'b1 && rx_empty == 1'b1, "R10 break", {flag_break, rx_empty}, 2'b11);

        // R11 clear
        @(negedge clk); status_clr = 1'b1;
        @(negedge clk); status_clr = 1'b0;
        @(negedge clk);
        check({flag_overrun, flag_framing, flag_parity, flag_break} == 4'b0, "R11 clear",
              {flag_overrun, flag_framing, flag_parity, flag_break}, 0);

        // R6 multidrop filter
        @(negedge clk); char_bits = 4'd9; md_en = 1'b1; node_addr = 8'h5A;
        send_raw(9'h011, 9, 0, 1'b0, 1'b1);
        send_raw(9'h15A, 9, 0, 1'b0, 1'b1);
        send_raw(9'h022, 9, 0, 1'b0, 1'b1);
        send_raw(9'h033, 9, 0, 1'b0, 1'b1);
        send_raw(9'h1A0, 9, 0, 1'b0, 1'b1);
        send_raw(9'h044, 9, 0, 1'b0, 1'b1);
        rx_pop(got);
        check(got == 9'h022, "R6 first data after match", got, 9'h022);
        rx_pop(got);
        check(got == 9'h033, "R6 second data", got, 9'h033);
        @(negedge clk);
        check(rx_empty == 1'b1, "R6 filtered others", rx_empty, 1);

        // R7 software flow control
        @(negedge clk); md_en = 1'b0; char_bits = 4'd8; sw_flow_en = 1'b1;
        send_raw(9'h013, 8, 0, 1'b0, 1'b1);
        check(rx_empty == 1'b1, "R7 pause code not stored", rx_empty, 1);
        tx_push(9'h041);
        low_seen = 0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1;
        end
        check(low_seen == 0, "R7 transmit paused", low_seen, 0);
        send_raw(9'h011, 8, 0, 1'b0, 1'b1);
        low_seen = 0;
        for (int t = 0; t < 400; t++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1;
        end
        check(low_seen == 1, "R7 transmit resumed", low_seen, 1);
        check(rx_empty == 1'b1, "R7 resume code not stored", rx_empty, 1);
        @(negedge clk); sw_flow_en = 1'b0;
        send_raw(9'h013, 8, 0, 1'b0, 1'b1);
        rx_pop(got);
        check(got == 9'h013, "R7 code stored when disabled", got, 9'h013);

        // R5 R8 queue full and clear-to-send
        lb = 1'b1;
        @(negedge clk); hw_flow_en = 1'b1; cts_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) tx_push(9'(9'h030 + i));
        @(negedge clk);
        check(tx_full == 1'b1, "R5 tx_full", tx_full, 1);
        tx_push(9'h0AA);
        low_seen = 0;
        for (int t = 0; t < 300; t++) begin
            @(negedge clk);
            if (txd == 1'b0) low_seen = 1;
        end
        check(low_seen == 0, "R8 cts holds transmit", low_seen, 0);
        @(negedge clk); cts_n = 1'b0;
        repeat (3600) @(negedge clk);
        check(rts_n == 1'b1, "R8 rts_n near full", rts_n, 1);
        for (int i = 0; i < DEPTH; i++) begin
            rx_pop(got);
            check(got == 9'(9'h030 + i), "R5 order", got, 9'(9'h030 + i));
        end
        @(negedge clk);
        check(rx_empty == 1'b1, "R5 write to full queue dropped", rx_empty, 1);
        check(rts_n == 1'b0, "R8 rts_n released", rts_n, 0);

        // R9 overrun
        for (int i = 0; i < DEPTH; i++) tx_push(9'(9'h050 + i));
        repeat (3600) @(negedge clk);
        check(flag_overrun == 1'b0, "R9 no overrun yet", flag_overrun, 0);
        tx_push(9'h077);
        repeat (400) @(negedge clk);
        check(flag_overrun == 1'b1, "R9 overrun flag", flag_overrun, 1);
        rx_pop(got);
        check(got == 9'h050, "R9 queue intact", got, 9'h050);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule